// File: doc/BRIEF.md
# Posted Write Bridge Buffer

This block sits between a fast upstream write port and a slow downstream write port. The upstream side presents byte or halfword writes, each with an address. In buffered mode a write is taken into a small first-in first-out store in the cycle it is offered, provided it fits. The upstream side is then free to continue, and the stored writes leave one at a time over a valid/ready handshake whenever the slow side can start its next cycle.

Room in the store is counted in bytes, not in entries. Four bytes of write data are available, so the store holds two halfwords, four bytes, or a halfword and two bytes. A write that does not fit is held off until enough earlier writes have drained. Buffering does not move data to the slow side any sooner. Its only effect is that the fast side does not wait.

Dropping the enable selects bypass mode. In bypass mode the upstream request is wired straight through to the downstream port, and the upstream side waits until the downstream side accepts the write. The block does not enter bypass mode while buffered writes remain, so write order is always kept.

Top module: `pwb_top`

## Requirements
- R1: At most 4 bytes are buffered. Four byte writes (size 0) are accepted back to back while `dn_ready` is low, and a fifth write is refused.
- R2: A halfword write (size 1) uses two bytes of room. Two halfwords fill the buffer, and any write that would take the byte total above 4 is refused.
- R3: In buffered mode, with the enable high and enough free room, `up_ready` is high in the same cycle as `up_valid`, whatever the value of `dn_ready`.
- R4: Buffered writes leave in arrival order, and each one keeps its own address, size and data.
- R5: `dn_valid` rises in the cycle after the first write is accepted. The head entry stays on `dn_addr`/`dn_size`/`dn_data` until `dn_ready` is seen, and exactly one entry leaves per downstream handshake. `dn_valid` is low whenever the buffer is empty.
- R6: The room check uses the byte count at the start of the cycle. A refused write is accepted in the first cycle after drains have freed enough bytes.
- R7: In bypass mode, `dn_valid` follows `up_valid`, the downstream fields equal the upstream fields, and `up_ready` equals `dn_ready`. The upstream side stalls until the downstream side accepts.
- R8: When the enable is low and the buffer is not empty, upstream writes are refused and the buffered writes drain first. Bypass takes effect one cycle after the buffer is seen empty with the enable low. Raising the enable returns the block to buffered mode on the next cycle.
- R9: For a byte write, `dn_data[15:8]` is zero and `dn_data[7:0]` carries `up_data[7:0]`. This holds in both modes.
- R10: Reset, including reset in the middle of operation, empties the buffer, drives `dn_valid` low and selects buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_en | input | 1 | 1 = buffered mode, 0 = bypass mode (bypass starts once the buffer is empty) |
| up_valid | input | 1 | Upstream write request |
| up_addr | input | AW | Upstream write address |
| up_size | input | 1 | Write size: 0 = byte, 1 = halfword |
| up_data | input | 16 | Upstream write data (the low byte is used for byte writes) |
| up_ready | output | 1 | The upstream write completes in a cycle where `up_valid` and `up_ready` are both high |
| dn_valid | output | 1 | Downstream write request |
| dn_addr | output | AW | Downstream write address |
| dn_size | output | 1 | Downstream write size, same encoding as `up_size` |
| dn_data | output | 16 | Downstream write data; the upper byte is zero for byte writes |
| dn_ready | input | 1 | The downstream side accepts the write in this cycle |

## Verification
The bench builds the block with its default parameters: a 16-bit address and 4 bytes of room. With these values, every sequence of four byte or halfword writes can be enumerated. The bench sweeps all sixteen size patterns while the drain is blocked. For each pattern it computes arithmetically where the first refusal must fall, then drains the buffer and compares order and fields. Directed sequences cover the cycle at which a stalled write is released, the drain-then-bypass switch-over, the bypass pass-through with byte masking, and a reset applied while the buffer is full.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int DW = 16;

  // size encoding: 0 = byte, 1 = halfword
  function automatic int size_bytes(input logic sz);
    return sz ? 2 : 1;
  endfunction

  function automatic logic room_for(input int used, input int req, input int cap);
    return (used + req) <= cap;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic sz, input logic [DW-1:0] d);
    return sz ? d : {8'h00, d[7:0]};
  endfunction
endpackage

// File: rtl/pwb_credit.sv
module pwb_credit #(
  parameter int CAP_BYTES = 4,
  localparam int UW = $clog2(CAP_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [UW-1:0] push_bytes,
  input  logic          pop,
  input  logic [UW-1:0] pop_bytes,
  output logic [UW-1:0] used
);
  logic [UW-1:0] used_nxt;

  always_comb begin
    used_nxt = used;
    if (push) used_nxt = used_nxt + push_bytes;
    if (pop)  used_nxt = used_nxt - pop_bytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used <= '0;
    else        used <= used_nxt;
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= CAP_BYTES);

  p_push_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(used) + int'(push_bytes)) <= CAP_BYTES);

  p_pop_covered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> used >= pop_bytes);
endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [AW-1:0]          in_addr,
  input  logic                   in_size,
  input  logic [pwb_pkg::DW-1:0] in_data,
  input  logic                   pop,
  output logic [AW-1:0]          hd_addr,
  output logic                   hd_size,
  output logic [pwb_pkg::DW-1:0] hd_data,
  output logic [CW-1:0]          count
);
  logic [AW-1:0]          addr_q [DEPTH];
  logic                   size_q [DEPTH];
  logic [pwb_pkg::DW-1:0] data_q [DEPTH];
  logic [PW-1:0]          wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(s)) begin
        addr_q[s] <= in_addr;
        size_q[s] <= in_size;
        data_q[s] <= in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign hd_addr = addr_q[rd_ptr];
  assign hd_size = size_q[rd_ptr];
  assign hd_data = data_q[rd_ptr];

  p_slot_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(count) < DEPTH);

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/pwb_mode.sv
module pwb_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_en,
  input  logic empty,
  output logic bypass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bypass <= 1'b0;
    else if (buf_en) bypass <= 1'b0;
    else if (empty)  bypass <= 1'b1;
  end

  p_enter_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !empty && !bypass) |=> !bypass);

  p_leave_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |=> !bypass);
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int AW        = 16,
  parameter int CAP_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   buf_en,
  input  logic                   up_valid,
  input  logic [AW-1:0]          up_addr,
  input  logic                   up_size,
  input  logic [pwb_pkg::DW-1:0] up_data,
  output logic                   up_ready,
  output logic                   dn_valid,
  output logic [AW-1:0]          dn_addr,
  output logic                   dn_size,
  output logic [pwb_pkg::DW-1:0] dn_data,
  input  logic                   dn_ready
);
  localparam int DEPTH = CAP_BYTES;
  localparam int UW    = $clog2(CAP_BYTES + 1);
  localparam int CW    = $clog2(DEPTH + 1);

  logic                   bypass;
  logic [UW-1:0]          used;
  logic [CW-1:0]          entries;
  logic [AW-1:0]          hd_addr;
  logic                   hd_size;
  logic [pwb_pkg::DW-1:0] hd_data;
  logic [UW-1:0]          req_bytes, hd_bytes;
  logic                   fits, buf_empty, buf_valid;
  logic                   push_evt, pop_evt, drain_wait;

  assign req_bytes = UW'(pwb_pkg::size_bytes(up_size));
  assign hd_bytes  = UW'(pwb_pkg::size_bytes(hd_size));
  assign fits      = pwb_pkg::room_for(int'(used), int'(req_bytes), CAP_BYTES);
  assign buf_empty = (used == '0);
  assign buf_valid = !buf_empty;

  assign push_evt   = !bypass && buf_en && up_valid && fits;
  assign pop_evt    = !bypass && buf_valid && dn_ready;
  assign drain_wait = !bypass && !buf_en;

  pwb_credit #(.CAP_BYTES(CAP_BYTES)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .push_bytes(req_bytes),
    .pop(pop_evt), .pop_bytes(hd_bytes),
    .used(used)
  );

  pwb_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .in_addr(up_addr), .in_size(up_size),
    .in_data(pwb_pkg::lane_mask(up_size, up_data)),
    .pop(pop_evt),
    .hd_addr(hd_addr), .hd_size(hd_size), .hd_data(hd_data),
    .count(entries)
  );

  pwb_mode u_mode (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en),
    .empty(buf_empty), .bypass(bypass)
  );

  always_comb begin
    if (bypass) begin
      up_ready = dn_ready;
      dn_valid = up_valid;
      dn_addr  = up_addr;
      dn_size  = up_size;
      dn_data  = pwb_pkg::lane_mask(up_size, up_data);
    end else begin
      up_ready = buf_en && fits;
      dn_valid = buf_valid;
      dn_addr  = hd_addr;
      dn_size  = hd_size;
      dn_data  = hd_data;
    end
  end

  p_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && buf_en && up_valid && buf_empty) |-> up_ready);

  p_hold_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_addr) && $stable(dn_size) && $stable(dn_data)));

  p_books_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (entries == '0) == buf_empty);

  p_bypass_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> buf_empty);

  p_drain_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_wait |-> !up_ready);

  p_byte_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_size) |-> dn_data[15:8] == 8'h00);
endmodule

// File: tb/sim_pwb_top.sv
module sim_pwb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_en = 1'b1;
  logic        up_valid = 1'b0;
  logic [15:0] up_addr = '0;
  logic        up_size = 1'b0;
  logic [15:0] up_data = '0;
  logic        up_ready;
  logic        dn_valid;
  logic [15:0] dn_addr;
  logic        dn_size;
  logic [15:0] dn_data;
  logic        dn_ready = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [15:0] q_addr [8];
  logic        q_size [8];
  logic [15:0] q_data [8];
  int          qn;

  pwb_top u0 (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en),
    .up_valid(up_valid), .up_addr(up_addr), .up_size(up_size), .up_data(up_data),
    .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_size(dn_size), .dn_data(dn_data),
    .dn_ready(dn_ready)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic sz, input logic [15:0] d);
    return sz ? d : (d & 16'h00FF);
  endfunction

  task automatic drive(input logic v, input logic [15:0] a, input logic sz, input logic [15:0] d);
    @(negedge clk);
    up_valid = v; up_addr = a; up_size = sz; up_data = d;
    #5;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10 dn_valid after reset", dn_valid, 1'b0);
    chk("R10 ready after reset", up_ready, 1'b1);

    // R1 R2 R3 R4 R5 R9: all 16 size patterns of four writes, drain blocked
    for (int p = 0; p < 16; p++) begin
      int used;
      used = 0;
      qn = 0;
      dn_ready = 1'b0;
      for (int i = 0; i < 4; i++) begin
        logic sz;
        logic [15:0] a, d;
        logic exp_ok;
        sz = p[i];
        a  = 16'(16'h0100 * p + i);
        d  = 16'((p << 8) | (i << 4) | 16'hF00C);
        drive(1'b1, a, sz, d);
        exp_ok = (used + (sz ? 2 : 1)) <= 4;
        chk(sz ? "R2 R3 halfword room" : "R1 R3 byte room", up_ready, exp_ok);
        if (!exp_ok) break;
        q_addr[qn] = a; q_size[qn] = sz; q_data[qn] = exp_data(sz, d);
        qn++;
        used += sz ? 2 : 1;
      end
      drive(1'b0, '0, 1'b0, '0);
      chk("R5 dn_valid after pushes", dn_valid, 1'b1);
      for (int k = 0; k < qn; k++) begin
        @(negedge clk); dn_ready = 1'b1; #5;
        chk("R5 head valid", dn_valid, 1'b1);
        chk("R4 order addr", dn_addr, q_addr[k]);
        chk("R4 size", dn_size, q_size[k]);
        chk("R9 R4 data", dn_data, q_data[k]);
      end
      @(negedge clk); dn_ready = 1'b0; #5;
      chk("R5 empty no valid", dn_valid, 1'b0);
    end

    // R6: byte refused behind two halfwords, released one cycle after a drain
    drive(1'b1, 16'h0600, 1'b1, 16'h1111);
    drive(1'b1, 16'h0602, 1'b1, 16'h2222);
    drive(1'b1, 16'h0604, 1'b0, 16'h0033);
    chk("R6 full refuses byte", up_ready, 1'b0);
    @(negedge clk); dn_ready = 1'b1; #5;
    chk("R6 no same-cycle reuse", up_ready, 1'b0);
    @(negedge clk); dn_ready = 1'b0; #5;
    chk("R6 released after drain", up_ready, 1'b1);
    drive(1'b0, '0, 1'b0, '0);
    chk("R4 second halfword at head", dn_addr, 16'h0602);
    @(negedge clk); dn_ready = 1'b1; #5;
    @(negedge clk); #5;
    chk("R4 released byte follows", dn_addr, 16'h0604);
    @(negedge clk); dn_ready = 1'b0; #5;
    chk("R5 empty after R6", dn_valid, 1'b0);

    // R8: enable drops with writes pending
    drive(1'b1, 16'h0A01, 1'b0, 16'h00A1);
    drive(1'b1, 16'h0A02, 1'b1, 16'hA2A2);
    @(negedge clk);
    buf_en = 1'b0; up_valid = 1'b1; up_addr = 16'h0B00; up_size = 1'b1; up_data = 16'h1234;
    #5;
    chk("R8 refused while pending", up_ready, 1'b0);
    chk("R8 head still buffered", dn_addr, 16'h0A01);
    @(negedge clk); dn_ready = 1'b1; #5;
    chk("R8 drain first", dn_addr, 16'h0A01);
    chk("R8 still refused", up_ready, 1'b0);
    @(negedge clk); #5;
    chk("R8 drain second", dn_addr, 16'h0A02);
    chk("R8 still refused 2", up_ready, 1'b0);
    @(negedge clk); #5;
    chk("R8 empty before switch", dn_valid, 1'b0);
    chk("R8 no accept before switch", up_ready, 1'b0);
    @(negedge clk); dn_ready = 1'b0; #5;
    // R7: bypass pass-through
    chk("R7 valid passes", dn_valid, 1'b1);
    chk("R7 addr passes", dn_addr, 16'h0B00);
    chk("R7 stalls without dn_ready", up_ready, 1'b0);
    @(negedge clk); dn_ready = 1'b1; #5;
    chk("R7 ready follows", up_ready, 1'b1);
    chk("R7 data passes", dn_data, 16'h1234);
    drive(1'b1, 16'h0C00, 1'b0, 16'hABCD);
    chk("R9 bypass byte mask", dn_data, 16'h00CD);
    chk("R7 size passes", dn_size, 1'b0);
    drive(1'b0, '0, 1'b0, '0);
    chk("R7 no request no valid", dn_valid, 1'b0);

    // R8: enable back on, buffered next cycle
    @(negedge clk); buf_en = 1'b1; dn_ready = 1'b0;
    up_valid = 1'b1; up_addr = 16'h0D00; up_size = 1'b1; up_data = 16'h5555;
    #5;
    chk("R8 still bypass this cycle", up_ready, 1'b0);
    @(negedge clk); #5;
    chk("R8 R3 buffered again", up_ready, 1'b1);

    // R10: reset with a full buffer
    drive(1'b1, 16'h0D02, 1'b1, 16'h6666);
    drive(1'b0, '0, 1'b0, '0);
    chk("R1 full before reset", dn_valid, 1'b1);
    @(negedge clk); rst_n = 1'b0; #5;
    chk("R10 reset drops valid", dn_valid, 1'b0);
    @(negedge clk); rst_n = 1'b1; #5;
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 16'(16'h0E00 + i), 1'b0, 16'(i));
      chk("R10 R1 room restored", up_ready, 1'b1);
    end
    drive(1'b1, 16'h0E04, 1'b0, 16'h0004);
    chk("R1 fifth byte refused", up_ready, 1'b0);
    drive(1'b0, '0, 1'b0, '0);

    finish_run();
  end
endmodule